// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block steers interrupt requests from a set of device lines toward the processor side. Each input line owns one 64-bit programmable entry. The entry sets the line's active level, chooses edge or level sensing, and can mask the line. It also holds the vector, delivery mode, destination mode and destination that go with a delivery request. The block conditions every line according to its entry and records which lines have a delivery pending. It then offers the lowest-numbered pending, unmasked line on a single valid/ready request port.

For level-sensed lines, a remote-request flag is set when the processor side accepts the request. While the flag is set, the line cannot raise a new request, even if its input stays active. An end-of-interrupt notice that carries the entry's vector clears the flag. Software reads and writes the table 32 bits at a time through an index/data port. Word index 2n addresses the low half of entry n and 2n+1 its high half. Inputs are expected to be synchronous to the block clock.

Top module: `irq_route_table`

## Requirements
- R1: Word index 2n reads and writes bits 31:0 of entry n, and index 2n+1 reads and writes bits 63:32 of entry n; an index at or beyond 2 x lines reads zero. After reset every entry reads 0x00010000 in the low word (mask bit 16 set) and 0 in the high word, and no request is presented.
- R2: For an entry with trigger bit 15 = 1 (edge), an inactive-to-active change of the conditioned input on an unmasked entry sets delivery status (low-word bit 12) and presents a request from the next cycle. A cycle with req_valid and req_ready both high accepts the request and clears the status. An input that stays active does not request again.
- R3: An entry with mask bit 16 = 1 never presents a request, and an edge that arrives while it is masked is discarded, so unmasking it later raises nothing.
- R4: For an entry with trigger bit 15 = 0 (level), an active unmasked input presents a request. Acceptance sets the remote-request flag (low-word bit 14), and the request is then withdrawn.
- R5: While a level entry's remote-request flag is set, no request is raised from it. An end-of-interrupt with a different vector leaves the flag set. One whose vector equals the entry's bits 7:0 clears it, and a still-active input then requests again two cycles later.
- R6: Polarity bit 13 = 1 treats a high input as active, and 0 treats a low input as active.
- R7: When several entries are pending, the request carries the lowest-numbered one. Each acceptance retires exactly that entry, and the next one follows.
- R8: The request carries the entry's vector (bits 7:0), delivery mode (bits 10:8: 000 fixed, 001 lowest priority, 010 system management, 100 non-maskable, 101 init, 111 external, with 011 and 110 reserved and passed through as written), destination mode (bit 11, 1 logical, 0 physical) and destination (bits 63:56).
- R9: Bits 12 and 14 are read-only, and reserved bits 31:17 and 47:32 read zero. Writes to any of them have no effect. The extended destination (bits 55:48) is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 24 | Interrupt request lines, one per entry |
| cfg_wr | input | 1 | Write strobe for the table port |
| cfg_index | input | 6 | 32-bit word index into the table |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_index (combinational) |
| req_valid | output | 1 | A delivery request is presented |
| req_ready | input | 1 | Processor side accepts the presented request |
| req_vector | output | 8 | Vector of the presented request |
| req_mode | output | 3 | Delivery mode of the presented request |
| req_dest_mode | output | 1 | Destination mode, 1 logical, 0 physical |
| req_dest | output | 8 | Destination of the presented request |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt notice |

## Verification
The bench sweeps every pair of simultaneously raised edge lines. A priority encoder that favoured the higher index, or retired the wrong entry on acceptance, would present vectors out of order. The level path is checked with the input held active across acceptance and across a mismatched end-of-interrupt. A design that ignored the remote flag would storm the request port, and one that cleared the flag on any notice would request too early. Masked edges, active-low inputs and writes of all ones to the read-only and reserved bits are each driven. A block that latched masked edges, or let software set status bits, would show up at the request port or in readback.

// File: rtl/irq_route_pkg.sv
// Shared field positions, write masks and delivery-mode codes for the
// interrupt redirection table. Field positions are fixed because the
// processor side and software decode them.
package irq_route_pkg;
    localparam int ENTRY_W   = 64;
    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int DSTM_BIT  = 11;
    localparam int STAT_BIT  = 12;
    localparam int POL_BIT   = 13;
    localparam int RREQ_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 56;

    // writable bits of each 32-bit half
    localparam logic [31:0] LO_WMASK = 32'h0001_AFFF;
    localparam logic [31:0] HI_WMASK = 32'hFFFF_0000;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMGMT  = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMASK  = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV6   = 3'b110,
        DM_EXTERN = 3'b111
    } dmode_e;
endpackage

// File: rtl/irq_entry_store.sv
// Holds the programmable table entries and applies 32-bit writes.
// Assumes: cfg_index addresses a half-entry (bit 0 picks the half).
// Read-only and reserved bits are never stored, so they stay zero.
module irq_entry_store
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic [IDX_W-1:0]                  cfg_index,
    input  logic [31:0]                       cfg_wdata,
    output logic [NUM_LINES-1:0][ENTRY_W-1:0] entries
);
    localparam int LINE_W = IDX_W - 1;

    logic [LINE_W-1:0] wr_line;
    assign wr_line = cfg_index[IDX_W-1:1];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ent
        // Update one entry's halves on a write that addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= {32'h0, LO_RESET};
            end else if (cfg_wr && wr_line == LINE_W'(g)) begin
                if (cfg_index[0])
                    entries[g][63:32] <= cfg_wdata & HI_WMASK;
                else
                    entries[g][31:0]  <= cfg_wdata & LO_WMASK;
            end
        end
    end
endmodule

// File: rtl/irq_line_cond.sv
// Per-line conditioning: polarity, edge detect, delivery status and the
// remote-request flag of level-sensed entries.
// Assumes: irq_in is synchronous to clk; accept is high for one cycle when
// the processor side takes this line's request.
module irq_line_cond (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_in,
    input  logic       pol_high,
    input  logic       trig_edge,
    input  logic       mask,
    input  logic [7:0] vector,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    input  logic       accept,
    output logic       status,
    output logic       remote,
    output logic       cand
);
    logic active, prev_q, edge_now, eoi_hit;

    assign active   = pol_high ? irq_in : ~irq_in;
    assign edge_now = active & ~prev_q;
    assign eoi_hit  = eoi_valid && (eoi_vector == vector);
    assign cand     = status & ~mask;

    // Remember last conditioned level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    // Delivery status: latched edge, or live level gated by mask and remote.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (trig_edge)
            status <= (status & ~accept) | (edge_now & ~mask);
        else
            status <= active & ~mask & ~remote & ~accept;
    end

    // Remote-request flag: set on level acceptance, cleared by matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)                  remote <= 1'b0;
        else if (accept && !trig_edge) remote <= 1'b1;
        else if (eoi_hit)            remote <= 1'b0;
    end

    // R2
    edge_accept_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && accept && !edge_now) |=> !status);
    // R3
    masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && mask && !status) |=> !status);
    // R4
    level_accept_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !trig_edge) |=> remote);
    // R5
    remote_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_edge && remote && !eoi_hit) |=> !status);
endmodule

// File: rtl/irq_prio_pick.sv
// Picks the lowest-numbered candidate line and reports its index.
// Assumes: at most NUM_LINES candidates; grant is one-hot or zero.
module irq_prio_pick #(
    parameter int NUM_LINES = 24,
    parameter int LINE_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cand,
    output logic [NUM_LINES-1:0] grant,
    output logic [LINE_W-1:0]    idx,
    output logic                 any
);
    // Scan from the top down so the lowest set index wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--)
            if (cand[i]) idx = LINE_W'(i);
        any   = |cand;
        grant = any ? (NUM_LINES'(1) << idx) : '0;
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R7
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((cand & ((NUM_LINES'(1) << idx) - NUM_LINES'(1))) == '0));
endmodule

// File: rtl/irq_route_table.sv
// Top of the interrupt redirection table: table storage, per-line
// conditioning, lowest-index selection, request port and readback.
// Assumes: synchronous inputs; request is combinational from registered
// state and may be withdrawn if its line is masked before acceptance.
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int IDX_W    = LINE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_index,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [7:0]           req_vector,
    output logic [2:0]           req_mode,
    output logic                 req_dest_mode,
    output logic [7:0]           req_dest,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector
);
    logic [NUM_LINES-1:0][ENTRY_W-1:0] entries;
    logic [NUM_LINES-1:0] status, remote, cand, grant, accept;
    logic [LINE_W-1:0]    sel;
    logic                 any;
    logic [LINE_W-1:0]    rd_line;

    irq_entry_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_index(cfg_index),
        .cfg_wdata(cfg_wdata), .entries(entries)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cond u_cond (
            .clk(clk), .rst_n(rst_n), .irq_in(irq_in[g]),
            .pol_high(entries[g][POL_BIT]), .trig_edge(entries[g][TRIG_BIT]),
            .mask(entries[g][MASK_BIT]), .vector(entries[g][VEC_LSB +: 8]),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .accept(accept[g]), .status(status[g]), .remote(remote[g]),
            .cand(cand[g])
        );
    end

    irq_prio_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .cand(cand), .grant(grant),
        .idx(sel), .any(any)
    );

    // Drive the request port from the selected entry.
    always_comb begin
        req_valid     = any;
        req_vector    = entries[sel][VEC_LSB +: 8];
        req_mode      = entries[sel][MODE_LSB +: 3];
        req_dest_mode = entries[sel][DSTM_BIT];
        req_dest      = entries[sel][DEST_LSB +: 8];
        accept        = grant & {NUM_LINES{req_valid & req_ready}};
    end

    // Return the addressed half with live status and remote bits overlaid.
    assign rd_line = cfg_index[IDX_W-1:1];
    always_comb begin
        cfg_rdata = '0;
        if (rd_line < LINE_W'(NUM_LINES)) begin
            if (cfg_index[0])
                cfg_rdata = entries[rd_line][63:32];
            else
                cfg_rdata = entries[rd_line][31:0]
                          | (32'(status[rd_line]) << STAT_BIT)
                          | (32'(remote[rd_line]) << RREQ_BIT);
        end
    end

    // R7
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept));
    // R3
    no_masked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !entries[sel][MASK_BIT]);
endmodule

// File: tb/sim_irq_route_table.sv
module sim_irq_route_table;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_index = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [7:0]  req_vector, req_dest;
    logic [2:0]  req_mode;
    logic        req_dest_mode;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    irq_route_table u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_wr(cfg_wr),
        .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
        .req_mode(req_mode), .req_dest_mode(req_dest_mode), .req_dest(req_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_index = 6'(idx); cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        cfg_index = 6'(idx);
        #1 d = cfg_rdata;
    endtask

    task automatic prog(input int line, input logic [31:0] lo, input logic [31:0] hi);
        wr(2 * line, lo);
        wr(2 * line + 1, hi);
    endtask

    task automatic take();
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        step();
        eoi_valid = 1'b0;
    endtask

    // edge, active high, unmasked, given vector
    function automatic logic [31:0] edge_lo(input logic [7:0] v);
        return 32'h0000_A000 | 32'(v);
    endfunction

    initial begin
        logic [31:0] d, lo, hi;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 reset valid", 64'(req_valid), 64'd0);
        rd(0, d);  chk("R1 reset lo", 64'(d), 64'h0001_0000);
        rd(47, d); chk("R1 reset hi", 64'(d), 64'h0);
        rd(50, d); chk("R1 out of range", 64'(d), 64'h0);

        // R2 R8 per-line edge sweep with all fields
        for (int i = 0; i < N; i++) begin
            lo = 32'h0000_A000 | 32'(8'h20 + i) | (32'(i % 8) << 8) | (32'(i % 2) << 11);
            hi = (32'((i * 7 + 3) % 256) << 24) | (32'(i) << 16);
            prog(i, lo, hi);
            rd(2 * i + 1, d); chk("R9 ext dest readback", 64'(d), 64'(hi));
            irq_in[i] = 1'b1;
            step();
            chk("R2 edge raises", 64'(req_valid), 64'd1);
            chk("R8 vector", 64'(req_vector), 64'(8'h20 + i));
            chk("R8 mode", 64'(req_mode), 64'(i % 8));
            chk("R8 dest mode", 64'(req_dest_mode), 64'(i % 2));
            chk("R8 dest", 64'(req_dest), 64'((i * 7 + 3) % 256));
            rd(2 * i, d); chk("R2 status set", 64'(d), 64'(lo | 32'h1000));
            take();
            chk("R2 accept clears", 64'(req_valid), 64'd0);
            step();
            chk("R2 held no retrigger", 64'(req_valid), 64'd0);
            irq_in[i] = 1'b0;
            prog(i, lo | 32'h0001_0000, 32'h0);
        end

        // R3 masked edge discarded
        prog(7, edge_lo(8'h77) | 32'h0001_0000, 32'h0);
        irq_in[7] = 1'b1;
        step();
        chk("R3 masked no req", 64'(req_valid), 64'd0);
        prog(7, edge_lo(8'h77), 32'h0);
        step();
        chk("R3 unmask no req", 64'(req_valid), 64'd0);
        rd(14, d); chk("R3 status clear", 64'(d), 64'(edge_lo(8'h77)));
        irq_in[7] = 1'b0;
        prog(7, 32'h0001_0000, 32'h0);

        // R6 active-low edge
        irq_in[11] = 1'b1;
        prog(11, 32'h0000_8000 | 32'h5B, 32'h0);
        step();
        chk("R6 high idle for active low", 64'(req_valid), 64'd0);
        irq_in[11] = 1'b0;
        step();
        chk("R6 low raises", 64'(req_valid), 64'd1);
        chk("R6 vector", 64'(req_vector), 64'h5B);
        take();
        prog(11, 32'h0001_0000, 32'h0);

        // R4 R5 level with remote flag
        prog(9, 32'h0000_2050, 32'h0);
        irq_in[9] = 1'b1;
        step();
        chk("R4 level raises", 64'(req_valid), 64'd1);
        chk("R4 level vector", 64'(req_vector), 64'h50);
        take();
        chk("R4 withdrawn", 64'(req_valid), 64'd0);
        rd(18, d); chk("R4 remote set", 64'(d), 64'h0000_6050);
        repeat (3) step();
        chk("R5 still blocked", 64'(req_valid), 64'd0);
        eoi(8'h51);
        step();
        chk("R5 wrong eoi no req", 64'(req_valid), 64'd0);
        rd(18, d); chk("R5 wrong eoi keeps flag", 64'(d), 64'h0000_6050);
        eoi(8'h50);
        chk("R5 one cycle after eoi", 64'(req_valid), 64'd0);
        step();
        chk("R5 request again", 64'(req_valid), 64'd1);
        irq_in[9] = 1'b0;
        step();
        chk("R4 level drop withdraws", 64'(req_valid), 64'd0);
        prog(9, 32'h0001_0000, 32'h0);

        // R9 read-only and reserved bits
        prog(20, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(40, d); chk("R9 lo readonly", 64'(d), 64'h0001_AFFF);
        rd(41, d); chk("R9 hi reserved", 64'(d), 64'hFFFF_0000);
        chk("R9 no req", 64'(req_valid), 64'd0);
        prog(20, 32'h0001_0000, 32'h0);

        // R7 all pairs, lowest first
        for (int i = 0; i < N; i++) prog(i, edge_lo(8'(8'h40 + i)), 32'h0);
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                irq_in[a] = 1'b1; irq_in[b] = 1'b1;
                step();
                chk("R7 first lower", 64'(req_vector), 64'(8'h40 + a));
                take();
                chk("R7 second higher", 64'(req_vector), 64'(8'h40 + b));
                take();
                chk("R7 idle after both", 64'(req_valid), 64'd0);
                irq_in[a] = 1'b0; irq_in[b] = 1'b0;
                step();
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule